// File: doc/BRIEF.md
# Bit-Sliced ALU with Set-Less-Than

A purely combinational arithmetic logic unit, `WIDTH` bits wide (32 by default). It is built as a chain of identical one-bit slices with one special slice at the most significant position. Each slice computes AND, OR and a full-adder sum of its two operand bits. It then picks one of these, or an external "less" bit, with a two-bit operation code. Carries ripple from each slice into the next higher one.

Two shared controls shape the operands before the slices see them:

- `a_invert_i` complements operand a in every slice.
- `b_negate_i` complements operand b in every slice and also injects a carry of 1 into bit 0. With this control, the adder forms a + ~b + 1 = a − b.

With both inversions applied, the AND path yields NOR. The top slice also produces two signals:

- A signed overflow flag, taken as the XOR of the carries into and out of the top bit.
- A "set" bit, which is the adder sign corrected by that overflow.

The set bit drives the less input of bit 0, so the less-than result is right even when a − b overflows. The block is meant as the execution unit of a simple processor datapath. Its result is expected to be registered downstream.

Top module: `slice_alu`

## Requirements
- R1: Control code {a_invert_i, b_negate_i, op_i} = 4'b0000 gives result_o = a_i & b_i.
- R2: Control code 4'b0001 gives result_o = a_i | b_i.
- R3: Control code 4'b0010 gives result_o = (a_i + b_i) mod 2^WIDTH, and carry_o equals the carry out of that sum (bit WIDTH).
- R4: Control code 4'b0110 gives result_o = (a_i − b_i) mod 2^WIDTH, and carry_o is 1 exactly when a_i ≥ b_i as unsigned numbers.
- R5: Control code 4'b1100 gives result_o = ~(a_i | b_i).
- R6: Control code 4'b0111 gives result_o[0] = 1 exactly when a_i < b_i as two's-complement numbers, and result_o[WIDTH-1:1] = 0. This holds also for operand pairs whose difference overflows.
- R7: overflow_o is 1 exactly when the adder's signed result overflows. Here the adder sums A' = a_invert_i ? ~a_i : a_i, B' = b_negate_i ? ~b_i : b_i and carry-in b_negate_i. Overflow means A' and B' have equal sign bits and the sum's sign bit differs from them. This applies whichever operation is selected.
- R8: zero_o is 1 exactly when every bit of result_o is 0.
- R9: For every one of the 16 control codes, the behaviour follows from op_i applied to A' and B' of R7:
  - 00 gives A' & B'.
  - 01 gives A' | B'.
  - 10 gives A' + B' + b_negate_i.
  - 11 gives a word whose bit 0 is the overflow-corrected sign of that sum and whose other bits are 0.
  - carry_o is always bit WIDTH of A' + B' + b_negate_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand a |
| b_i | input | WIDTH | Operand b |
| a_invert_i | input | 1 | Complement operand a in every slice |
| b_negate_i | input | 1 | Complement operand b and set carry into bit 0 |
| op_i | input | 2 | Slice output select: 00 AND, 01 OR, 10 sum, 11 less |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result word is all zeros |
| carry_o | output | 1 | Carry out of the top slice |
| overflow_o | output | 1 | Signed overflow of the adder |

## Verification
A 6-bit instance is swept over every operand pair under all 16 control codes. This separates slice selection, operand inversion and carry injection from one another, and it reaches every overflow and borrow pattern of a small word. The default 32-bit instance is then driven with the extreme operands, used both as equal pairs and as pairs whose difference overflows. These include the most negative value, the most positive value, zero, all ones and their neighbours. They confirm that the corrected sign, rather than the raw adder sign, decides less-than. Random 32-bit pairs under every control code then exercise long carry ripples across the whole chain.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_invert_i,
  input  logic    b_negate_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    result_o,
  output logic    sum_o,
  output logic    carry_o
);
  logic a_eff, b_eff;

  assign a_eff   = a_invert_i ? ~a_i : a_i;
  assign b_eff   = b_negate_i ? ~b_i : b_i;
  assign sum_o   = a_eff ^ b_eff ^ carry_i;
  assign carry_o = (b_eff & carry_i) | (a_eff & carry_i) | (a_eff & b_eff);

  always_comb begin
    unique case (op_i)
      OP_AND:  result_o = a_eff & b_eff;
      OP_OR:   result_o = a_eff | b_eff;
      OP_SUM:  result_o = sum_o;
      default: result_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_invert_i,
  input  logic    b_negate_i,
  input  logic    carry_i,
  input  alu_op_e op_i,
  output logic    result_o,
  output logic    carry_o,
  output logic    set_o,
  output logic    overflow_o
);
  logic sum;

  alu_bit_slice u_core (
    .a_i       (a_i),
    .b_i       (b_i),
    .a_invert_i(a_invert_i),
    .b_negate_i(b_negate_i),
    .carry_i   (carry_i),
    .less_i    (1'b0),
    .op_i      (op_i),
    .result_o  (result_o),
    .sum_o     (sum),
    .carry_o   (carry_o)
  );

  assign overflow_o = carry_i ^ carry_o;
  // sign corrected for overflow gives true signed less-than
  assign set_o      = sum ^ overflow_o;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             zero_o
);
  assign zero_o = ~|word_i;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_invert_i,
  input  logic             b_negate_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             overflow_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e        op;
  logic [WIDTH:0] carry;
  logic           set;

  assign op       = alu_op_e'(op_i);
  assign carry[0] = b_negate_i;

  for (genvar i = 0; i < MSB; i++) begin : g_slice
    logic sum_unused;
    alu_bit_slice u_slice (
      .a_i       (a_i[i]),
      .b_i       (b_i[i]),
      .a_invert_i(a_invert_i),
      .b_negate_i(b_negate_i),
      .carry_i   (carry[i]),
      .less_i    ((i == 0) ? set : 1'b0),
      .op_i      (op),
      .result_o  (result_o[i]),
      .sum_o     (sum_unused),
      .carry_o   (carry[i+1])
    );
  end

  alu_msb_slice u_msb (
    .a_i       (a_i[MSB]),
    .b_i       (b_i[MSB]),
    .a_invert_i(a_invert_i),
    .b_negate_i(b_negate_i),
    .carry_i   (carry[MSB]),
    .op_i      (op),
    .result_o  (result_o[MSB]),
    .carry_o   (carry[WIDTH]),
    .set_o     (set),
    .overflow_o(overflow_o)
  );

  assign carry_o = carry[WIDTH];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .word_i(result_o),
    .zero_o(zero_o)
  );
endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             a_invert_i,
  input logic             b_negate_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             carry_o,
  input logic             overflow_o
);
  logic [3:0] ctl;
  assign ctl = {a_invert_i, b_negate_i, op_i};

  always_comb begin
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R8
    if (ctl == 4'b0000) AST_AND_RESULT: assert (result_o == (a_i & b_i)); // R1
    if (ctl == 4'b0001) AST_OR_RESULT: assert (result_o == (a_i | b_i)); // R2
    if (ctl == 4'b0010) AST_ADD_RESULT: assert ({carry_o, result_o} == {1'b0, a_i} + {1'b0, b_i}); // R3
    if (ctl == 4'b0110) AST_SUB_RESULT: assert (result_o == WIDTH'(a_i - b_i)); // R4
    if (ctl == 4'b0110) AST_SUB_BORROW: assert (carry_o == (a_i >= b_i)); // R4
    if (ctl == 4'b1100) AST_NOR_RESULT: assert (result_o == ~(a_i | b_i)); // R5
    if (op_i == 2'b11) AST_SLT_UPPER_CLEAR: assert (result_o[WIDTH-1:1] == '0); // R6
    if (ctl == 4'b0111) AST_SLT_SIGNED: assert (result_o[0] == ($signed(a_i) < $signed(b_i))); // R6
    if (ctl == 4'b0010) AST_NO_OVERFLOW_ADD: assert (overflow_o ==
        ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (result_o[WIDTH-1] != a_i[WIDTH-1]))); // R7
  end
endmodule

bind slice_alu slice_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .a_invert_i(a_invert_i),
  .b_negate_i(b_negate_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .carry_o   (carry_o),
  .overflow_o(overflow_o)
);

// File: tb/tb_slice_alu.sv
module tb_slice_alu;
  localparam int NS = 6;
  localparam int NW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [NS-1:0] sa, sb, sr;
  logic          s_ai, s_bn, sz, sc, sv;
  logic [1:0]    s_op;
  logic [NW-1:0] wa, wb, wr;
  logic          w_ai, w_bn, wz, wc, wv;
  logic [1:0]    w_op;

  slice_alu #(.WIDTH(NS)) dut (
    .a_i(sa), .b_i(sb), .a_invert_i(s_ai), .b_negate_i(s_bn), .op_i(s_op),
    .result_o(sr), .zero_o(sz), .carry_o(sc), .overflow_o(sv));

  slice_alu #(.WIDTH(NW)) dut_w (
    .a_i(wa), .b_i(wb), .a_invert_i(w_ai), .b_negate_i(w_bn), .op_i(w_op),
    .result_o(wr), .zero_o(wz), .carry_o(wc), .overflow_o(wv));

  function automatic string req_of(input logic [3:0] ctl);
    case (ctl)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b1100: return "R5";
      4'b0111: return "R6";
      default: return "R9";
    endcase
  endfunction

  // arithmetic reference for an n-bit instance
  task automatic check(input int n, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] ctl, input logic [31:0] ar,
                       input logic az, input logic ac, input logic av);
    logic [63:0] mask, ea, eb, s;
    logic [31:0] er;
    logic        ez, ec, ev, sgn;
    bit          bad = 1'b0;
    mask = (64'd1 << n) - 64'd1;
    ea   = (ctl[3] ? ~{32'd0, a} : {32'd0, a}) & mask;
    eb   = (ctl[2] ? ~{32'd0, b} : {32'd0, b}) & mask;
    s    = ea + eb + {63'd0, ctl[2]};
    ec   = s[n];
    sgn  = s[n-1];
    ev   = (ea[n-1] == eb[n-1]) && (sgn != ea[n-1]);
    case (ctl[1:0])
      2'b00:   er = 32'(ea & eb);
      2'b01:   er = 32'(ea | eb);
      2'b10:   er = 32'(s & mask);
      default: er = {31'd0, sgn ^ ev};
    endcase
    ez = (er == 32'd0);
    vectors++;
    if (ar != er) begin
      bad = 1'b1;
      $display("FAIL %s result n=%0d a=%h b=%h ctl=%b actual=%h expected=%h",
               req_of(ctl), n, a, b, ctl, ar, er);
    end
    if (az != ez) begin
      bad = 1'b1;
      $display("FAIL R8 zero n=%0d a=%h b=%h ctl=%b actual=%b expected=%b",
               n, a, b, ctl, az, ez);
    end
    if (ac != ec) begin
      bad = 1'b1;
      $display("FAIL %s carry n=%0d a=%h b=%h ctl=%b actual=%b expected=%b",
               (ctl == 4'b0110) ? "R4" : (ctl == 4'b0010 ? "R3" : "R9"), n, a, b, ctl, ac, ec);
    end
    if (av != ev) begin
      bad = 1'b1;
      $display("FAIL R7 overflow n=%0d a=%h b=%h ctl=%b actual=%b expected=%b",
               n, a, b, ctl, av, ev);
    end
    if (bad) fails++;
  endtask

  task automatic apply_small(input logic [NS-1:0] a, input logic [NS-1:0] b, input logic [3:0] ctl);
    @(posedge clk);
    sa = a; sb = b; {s_ai, s_bn, s_op} = ctl;
    @(negedge clk);
    check(NS, 32'(a), 32'(b), ctl, 32'(sr), sz, sc, sv);
  endtask

  task automatic apply_wide(input logic [NW-1:0] a, input logic [NW-1:0] b, input logic [3:0] ctl);
    @(posedge clk);
    wa = a; wb = b; {w_ai, w_bn, w_op} = ctl;
    @(negedge clk);
    check(NW, a, b, ctl, wr, wz, wc, wv);
  endtask

  logic [31:0] corner [9];
  logic [3:0]  named  [6];

  initial begin
    sa = '0; sb = '0; {s_ai, s_bn, s_op} = 4'b0000;
    wa = '0; wb = '0; {w_ai, w_bn, w_op} = 4'b0000;
    corner = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff,
               32'h80000001, 32'h7ffffffe, 32'h55555555, 32'haaaaaaaa};
    named  = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

    // idle inputs: AND of zeros, zero flag set (R1, R8)
    @(negedge clk);
    check(NW, 32'd0, 32'd0, 4'b0000, wr, wz, wc, wv);

    // exhaustive sweep of the small instance over all control codes (R1..R9)
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < (1 << NS); a++)
        for (int b = 0; b < (1 << NS); b++)
          apply_small(NS'(a), NS'(b), 4'(c));

    // wide corners: extremes, equal pairs, overflowing differences (R3..R7)
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int k = 0; k < 6; k++)
          apply_wide(corner[i], corner[j], named[k]);

    // random wide operands under every control code (R9)
    for (int i = 0; i < 4000; i++)
      apply_wide($urandom, $urandom, 4'(i % 16));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule